// File: doc/BRIEF.md
# I2C Bus Transaction Monitor

This block listens to the two wires of an I2C bus and never drives them. Both lines are oversampled by the system clock and brought into its domain through synchronisers. A three-state machine turns the sampled traffic into typed event records: an opening START, a repeated START, the address byte split into a 7-bit address and a direction, each following data byte tagged read or write, and STOP. Every byte event also carries the acknowledge bit that came with it.

The states are IDLE (waits only for a START), ADDR (collects one 9-bit address frame) and DATA (collects data frames, or leaves on a repeated START or a STOP). The transitions are: IDLE to ADDR on START; ADDR to DATA when the ninth bit of the frame arrives; DATA to ADDR on a repeated START; and DATA to IDLE on STOP. A one-entry output register offers each event on a valid/ready stream. An event that arrives while the register is full and not being read is discarded and counted in a saturating drop counter. Only reset clears that counter.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, ev_valid is 0 and ev_drop_count is 0. No event appears until a START is seen.
- R2: In IDLE, a falling SDA while SCL is high produces event code 1 (START) with ev_data 0 and ev_nack 0, and the machine enters ADDR.
- R3: A bit is taken on each rising SCL, MSB first, and a frame is 9 bits long. At the end of the address frame the event has ev_data[6:0] set to the upper seven bits and ev_data[7] set to 0. The code is 3 (address read) when the eighth bit is 1 and 4 (address write) when it is 0.
- R4: The ninth bit of every frame appears as ev_nack: 0 means acknowledged and 1 means not acknowledged.
- R5: Each complete frame in DATA produces the full 8-bit byte. The code is 5 (data read) or 6 (data write), following the direction bit of the most recent address byte.
- R6: A START seen in DATA produces code 2 (repeated START) with data 0 and nack 0. It discards any partial data frame and returns to ADDR.
- R7: A rising SDA while SCL is high in DATA produces code 7 (STOP) with data 0 and nack 0 and returns to IDLE. The next START is then reported as code 1, not code 2.
- R8: In ADDR, START and STOP conditions are ignored and bit collection continues unchanged.
- R9: In IDLE, SCL pulses and STOP conditions produce no event.
- R10: While ev_valid is 1 and ev_ready is 0, the held event stays unchanged. Every event arriving during that time is dropped and increments ev_drop_count, which saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| ev_ready | input | 1 | Consumer accepts the offered event |
| ev_valid | output | 1 | An event is offered |
| ev_cmd | output | 4 | Event code (1 start, 2 repeated start, 3 address read, 4 address write, 5 data read, 6 data write, 7 stop) |
| ev_data | output | 8 | Address (bits 6:0) or data byte |
| ev_nack | output | 1 | Ninth bit of the frame, 1 means not acknowledged |
| ev_drop_count | output | DROP_W | Saturating count of dropped events |

## Verification
The assertions check on every cycle that the bit counter never runs past the ninth bit and that IDLE never holds an open transaction. They also check that a STOP event coincides with IDLE, that a plain START comes only out of IDLE, that a stalled event stays unchanged, and that the drop counter never goes down. Only the bench scenarios can show that whole transactions decode correctly: address and direction splitting, direction inherited by data bytes, repeated START discarding a partial frame, conditions ignored inside an address frame, and saturation of the drop counter under a long stall.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } mon_state_t;

    typedef enum logic [3:0] {
        EV_NONE    = 4'd0,
        EV_START   = 4'd1,
        EV_RSTART  = 4'd2,
        EV_ADDR_RD = 4'd3,
        EV_ADDR_WR = 4'd4,
        EV_DATA_RD = 4'd5,
        EV_DATA_WR = 4'd6,
        EV_STOP    = 4'd7
    } ev_code_t;

    typedef struct packed {
        ev_code_t   code;
        logic [7:0] data;
        logic       nack;
    } ev_rec_t;
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '1;
        else        chain_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '1;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2cmon_edges.sv
module i2cmon_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o
);
    logic primed_q, scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            primed_q <= 1'b1;
            scl_q    <= scl_i;
            sda_q    <= sda_i;
        end
    end

    assign start_o = primed_q && sda_q && !sda_i && scl_i;
    assign stop_o  = primed_q && !sda_q && sda_i && scl_i;
    assign rise_o  = primed_q && !scl_q && scl_i;
endmodule

// File: rtl/i2cmon_fsm.sv
module i2cmon_fsm
    import i2cmon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    stop_i,
    input  logic    rise_i,
    input  logic    sda_i,
    output logic    ev_stb_o,
    output ev_rec_t ev_rec_o
);
    localparam int CNT_W = $clog2(DATA_W + 2);

    mon_state_t        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [DATA_W-1:0] sh_q, sh_n;
    logic              rd_q, rd_n;
    logic              open_q, open_n;
    logic              stb_n;
    ev_rec_t           rec_n;
    logic              last_bit;

    assign last_bit = (cnt_q == CNT_W'(DATA_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sh_q     <= '0;
            rd_q     <= 1'b0;
            open_q   <= 1'b0;
            ev_stb_o <= 1'b0;
            ev_rec_o <= '{code: EV_NONE, data: '0, nack: 1'b0};
        end else begin
            state_q  <= state_n;
            cnt_q    <= cnt_n;
            sh_q     <= sh_n;
            rd_q     <= rd_n;
            open_q   <= open_n;
            ev_stb_o <= stb_n;
            ev_rec_o <= rec_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        rd_n    = rd_q;
        open_n  = open_q;
        stb_n   = 1'b0;
        rec_n   = '{code: EV_NONE, data: '0, nack: 1'b0};
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    stb_n      = 1'b1;
                    rec_n.code = open_q ? EV_RSTART : EV_START;
                    open_n     = 1'b1;
                    cnt_n      = '0;
                    sh_n       = '0;
                    state_n    = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (rise_i) begin
                    if (last_bit) begin
                        stb_n      = 1'b1;
                        rec_n.code = sh_q[0] ? EV_ADDR_RD : EV_ADDR_WR;
                        rec_n.data = {1'b0, sh_q[DATA_W-1:1]};
                        rec_n.nack = sda_i;
                        rd_n       = sh_q[0];
                        cnt_n      = '0;
                        sh_n       = '0;
                        state_n    = ST_DATA;
                    end else begin
                        sh_n  = {sh_q[DATA_W-2:0], sda_i};
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (rise_i) begin
                    if (last_bit) begin
                        stb_n      = 1'b1;
                        rec_n.code = rd_q ? EV_DATA_RD : EV_DATA_WR;
                        rec_n.data = sh_q;
                        rec_n.nack = sda_i;
                        cnt_n      = '0;
                        sh_n       = '0;
                    end else begin
                        sh_n  = {sh_q[DATA_W-2:0], sda_i};
                        cnt_n = cnt_q + 1'b1;
                    end
                end else if (start_i) begin
                    stb_n      = 1'b1;
                    rec_n.code = open_q ? EV_RSTART : EV_START;
                    open_n     = 1'b1;
                    cnt_n      = '0;
                    sh_n       = '0;
                    state_n    = ST_ADDR;
                end else if (stop_i) begin
                    stb_n      = 1'b1;
                    rec_n.code = EV_STOP;
                    open_n     = 1'b0;
                    cnt_n      = '0;
                    sh_n       = '0;
                    state_n    = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // R3
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DATA_W));

    // R7
    idle_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !open_q);

    // R7
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stb_o && ev_rec_o.code == EV_STOP) |-> (state_q == ST_IDLE));

    // R2
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stb_o && ev_rec_o.code == EV_START) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: rtl/i2cmon_outq.sv
module i2cmon_outq
    import i2cmon_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  ev_rec_t           rec_i,
    input  logic              ready_i,
    output logic              valid_o,
    output ev_rec_t           rec_o,
    output logic [DROP_W-1:0] drops_o
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic load, drop;

    assign load = stb_i && (!valid_o || ready_i);
    assign drop = stb_i && valid_o && !ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            rec_o   <= '{code: EV_NONE, data: '0, nack: 1'b0};
            drops_o <= '0;
        end else begin
            if (load) begin
                valid_o <= 1'b1;
                rec_o   <= rec_i;
            end else if (ready_i) begin
                valid_o <= 1'b0;
            end
            if (drop && drops_o != DROP_MAX) drops_o <= drops_o + 1'b1;
        end
    end

    // R10
    hold_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(rec_o)));

    // R10
    drop_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drops_o >= $past(drops_o));
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DROP_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              ev_ready,
    output logic              ev_valid,
    output logic [3:0]        ev_cmd,
    output logic [7:0]        ev_data,
    output logic              ev_nack,
    output logic [DROP_W-1:0] ev_drop_count
);
    logic [1:0] line_s;
    logic       start_w, stop_w, rise_w, stb_w;
    ev_rec_t    rec_w, out_rec;

    i2cmon_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_in, sda_in}), .q_o(line_s)
    );

    i2cmon_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_i(line_s[1]), .sda_i(line_s[0]),
        .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w)
    );

    i2cmon_fsm #(.DATA_W(8)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .stop_i(stop_w),
        .rise_i(rise_w), .sda_i(line_s[0]), .ev_stb_o(stb_w), .ev_rec_o(rec_w)
    );

    i2cmon_outq #(.DROP_W(DROP_W)) u_outq (
        .clk(clk), .rst_n(rst_n), .stb_i(stb_w), .rec_i(rec_w),
        .ready_i(ev_ready), .valid_o(ev_valid), .rec_o(out_rec),
        .drops_o(ev_drop_count)
    );

    assign ev_cmd  = out_rec.code;
    assign ev_data = out_rec.data;
    assign ev_nack = out_rec.nack;
endmodule

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;
    localparam int DW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, ready = 1'b1;
    logic ev_valid, ev_nack;
    logic [3:0] ev_cmd;
    logic [7:0] ev_data;
    logic [DW-1:0] drops;

    int tests = 0, fails = 0, n_ev = 0;
    logic [3:0] log_cmd [64];
    logic [7:0] log_dat [64];
    logic       log_nak [64];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_monitor #(.DROP_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .ev_ready(ready),
        .ev_valid(ev_valid), .ev_cmd(ev_cmd), .ev_data(ev_data),
        .ev_nack(ev_nack), .ev_drop_count(drops)
    );

    always @(negedge clk) begin
        if (rst_n && ev_valid && ready && n_ev < 64) begin
            log_cmd[n_ev] = ev_cmd;
            log_dat[n_ev] = ev_data;
            log_nak[n_ev] = ev_nack;
            n_ev++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(int idx, int cmd, int dat, int nak, string tag);
        if (idx >= n_ev) begin
            chk(0, tag, n_ev, idx + 1);
        end else begin
            chk(log_cmd[idx] == cmd, {tag, " code"}, log_cmd[idx], cmd);
            chk(log_dat[idx] == dat, {tag, " data"}, log_dat[idx], dat);
            chk(log_nak[idx] == nak, {tag, " nack"}, log_nak[idx], nak);
        end
    endtask

    task automatic b_start();  sda = 0; tick(Q); scl = 0; tick(Q); endtask
    task automatic b_bit(bit b); sda = b; tick(Q); scl = 1; tick(Q); scl = 0; tick(Q); endtask
    task automatic b_glitch0();
        sda = 0; tick(Q); scl = 1; tick(Q);
        sda = 1; tick(Q); sda = 0; tick(Q);
        scl = 0; tick(Q);
    endtask
    task automatic b_byte(logic [7:0] v, bit ack);
        for (int i = 7; i >= 0; i--) b_bit(v[i]);
        b_bit(ack);
    endtask
    task automatic b_stop();   sda = 0; tick(Q); scl = 1; tick(Q); sda = 1; tick(Q); endtask
    task automatic b_rstart(); sda = 1; tick(Q); scl = 1; tick(Q); sda = 0; tick(Q); scl = 0; tick(Q); endtask

    task automatic t_reset();
        chk(ev_valid == 0, "R1 valid after reset", ev_valid, 0);
        chk(drops == 0, "R1 drops after reset", drops, 0);
        tick(20);
        chk(n_ev == 0, "R1 no event before start", n_ev, 0);
    endtask

    task automatic t_idle_noise();
        n_ev = 0;
        for (int i = 0; i < 5; i++) begin scl = 0; tick(Q); scl = 1; tick(Q); end
        scl = 0; tick(Q); sda = 0; tick(Q); scl = 1; tick(Q); sda = 1; tick(Q);
        tick(10);
        chk(n_ev == 0, "R9 idle activity events", n_ev, 0);
    endtask

    task automatic t_write();
        n_ev = 0;
        b_start(); b_byte(8'hA0, 0); b_byte(8'h3C, 0); b_byte(8'hFF, 1); b_stop();
        tick(10);
        chk(n_ev == 5, "R5 write event count", n_ev, 5);
        expect_ev(0, 1, 0, 0, "R2 start");
        expect_ev(1, 4, 8'h50, 0, "R3 address write");
        expect_ev(2, 6, 8'h3C, 0, "R5 data write");
        expect_ev(3, 6, 8'hFF, 1, "R4 nack on data");
        expect_ev(4, 7, 0, 0, "R7 stop");
    endtask

    task automatic t_read_rstart();
        n_ev = 0;
        b_start(); b_byte(8'h42, 0); b_byte(8'h5A, 0);
        b_bit(1); b_bit(0); b_bit(1);
        b_rstart(); b_byte(8'h43, 0); b_byte(8'h81, 1); b_stop();
        b_start(); b_byte(8'h10, 1); b_stop();
        tick(10);
        chk(n_ev == 10, "R6 event count", n_ev, 10);
        expect_ev(2, 6, 8'h5A, 0, "R5 data write before restart");
        expect_ev(3, 2, 0, 0, "R6 repeated start");
        expect_ev(4, 3, 8'h21, 0, "R3 address read");
        expect_ev(5, 5, 8'h81, 1, "R5 data read");
        expect_ev(6, 7, 0, 0, "R7 stop");
        expect_ev(7, 1, 0, 0, "R7 fresh start after stop");
        expect_ev(8, 4, 8'h08, 1, "R4 nack on address");
    endtask

    task automatic t_addr_glitch();
        n_ev = 0;
        b_start(); b_glitch0();
        for (int i = 6; i >= 0; i--) b_bit(1'(8'h64 >> i));
        b_bit(0); b_stop();
        tick(10);
        chk(n_ev == 3, "R8 event count", n_ev, 3);
        expect_ev(1, 4, 8'h32, 0, "R8 address through glitch");
        expect_ev(2, 7, 0, 0, "R8 stop after frame");
    endtask

    task automatic t_backpressure();
        n_ev = 0;
        ready = 0;
        b_start(); b_byte(8'hA0, 0);
        tick(10);
        chk(ev_valid == 1, "R10 held valid", ev_valid, 1);
        chk(ev_cmd == 1, "R10 held code", ev_cmd, 1);
        chk(drops == 1, "R10 one drop", drops, 1);
        for (int i = 0; i < 9; i++) b_byte(8'(i), 0);
        tick(10);
        chk(drops == 7, "R10 saturated drops", drops, 7);
        chk(ev_cmd == 1, "R10 still held", ev_cmd, 1);
        ready = 1; tick(3);
        chk(n_ev == 1, "R10 one pop", n_ev, 1);
        chk(ev_valid == 0, "R10 empty after pop", ev_valid, 0);
        b_stop(); tick(10);
        expect_ev(1, 7, 0, 0, "R10 stop after stall");
        chk(drops == 7, "R10 sticky drops", drops, 7);
    endtask

    initial begin
        tick(5);
        rst_n = 1;
        tick(2);
        t_reset();
        t_idle_noise();
        t_write();
        t_read_rstart();
        t_addr_glitch();
        t_backpressure();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule